// File: doc/BRIEF.md
# Frame-Counting HDLC Receive FIFO

This block buffers the received byte stream of one digital telephony channel and keeps count of whole HDLC frames as well as single bytes. An upstream deframer pushes each data byte and marks the end of every frame. A host pops bytes one at a time and, once it has consumed a frame, pulses a release strobe. Two pointer pairs track the buffer. One pair counts byte positions written and read. The other pair counts frames completed and released. The host sees the number of frames held, and it can also read all four pointers.

The write side never stalls and has no full flag, because the incoming line offers no flow control. Pointers roll over freely. All pointers come up as all ones after a hard reset or after a synchronous soft reset. If the frame count or the stored bytes exceed what the buffer can represent, a sticky overflow bit is set. Only a reset clears it. A single parameter selects a bearer-channel build (13-bit byte pointers, 5-bit frame count) or a signalling-channel build (9-bit byte pointers, frame count limited to 4 bits). `DEPTH_LOG2` sets the size of the byte store and must be smaller than the byte pointer width.

Top module: `hdlc_rx_frame_fifo`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both byte pointers read all ones across their full width (0x1FFF bearer, 0x1FF signalling). Both frame pointers read 0x1F (bearer) or 0x0F (signalling, where bit 4 is forced to 0). `frame_count`, `byte_fill` and `overflow` read 0.
- R2: A cycle with `soft_rst` high puts every pointer, `frame_count`, `byte_fill` and `overflow` into the same state as R1.
- R3: With `SIG_CHAN`=0 the byte pointers are 13 bits wide and the frame count wraps modulo 32. With `SIG_CHAN`=1 the byte pointers are 9 bits wide and the frame count and frame pointers wrap modulo 16.
- R4: Every cycle with `wr_en` high advances `wr_byte_ptr` by one, modulo the pointer width, with no exception. `wr_data` is stored at the address given by the low `DEPTH_LOG2` bits of the pointer value before the advance.
- R5: Every cycle with `wr_eof` high advances `wr_frame_ptr` by one. It may coincide with `wr_en`, or it may occur alone.
- R6: A cycle with `rd_en` high advances `rd_byte_ptr` by one. In the next cycle `rd_data` holds the byte stored at the address taken from the low bits of the pointer value before the advance.
- R7: `rd_frame_done` advances `rd_frame_ptr` only when `frame_count` is nonzero. When `frame_count` is zero it has no effect on any output.
- R8: `frame_count` equals `wr_frame_ptr` minus `rd_frame_ptr`, modulo 32 (bearer) or 16 (signalling). `byte_fill` equals `wr_byte_ptr` minus `rd_byte_ptr`, modulo the byte pointer width. Both change in the same cycle as the pointers.
- R9: `overflow` is set when `wr_eof` arrives while `frame_count` is already 31 (bearer) or 15 (signalling) and no frame release takes effect in the same cycle. The frame count then wraps.
- R10: `overflow` is set when `wr_en` arrives while `byte_fill` equals 2^`DEPTH_LOG2` and `rd_en` is low. The write still takes place.
- R11: Once set, `overflow` stays high until a hard or soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous soft reset, same effect as `rst` |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_data | input | 8 | Received byte |
| wr_eof | input | 1 | A frame has completed |
| rd_en | input | 1 | Pop one byte |
| rd_frame_done | input | 1 | Release one completed frame |
| rd_data | output | 8 | Popped byte, one cycle after `rd_en` |
| wr_byte_ptr | output | ZW | Write byte pointer (ZW = 13 or 9) |
| rd_byte_ptr | output | ZW | Read byte pointer |
| wr_frame_ptr | output | 5 | Write frame pointer, masked to 4 bits in signalling mode |
| rd_frame_ptr | output | 5 | Read frame pointer, masked likewise |
| frame_count | output | 5 | Frames held |
| byte_fill | output | ZW | Bytes held, modulo the pointer width |
| overflow | output | 1 | Sticky overflow |

## Verification
The bench drives a bearer instance and a signalling instance side by side with the same stimulus, each with a 16-byte store, and compares both against arithmetic models. Frames of mixed length, some closed on the same cycle as their last byte and some closed by a bare marker, show whether byte and frame counting are kept apart. A run of 32 bare markers after a soft reset separates the two wrap widths: the signalling build must flag overflow at the 16th marker and the bearer build at the 32nd. A 17-byte burst into the 16-byte store, releases issued on an empty buffer, and wrap-around of the pointers from their all-ones reset values cover the remaining edge cases.

// File: rtl/hfrf_pkg.sv
package hfrf_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 5;

  function automatic int byte_ptr_width(input bit sig);
    return sig ? 9 : 13;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_mask(input bit sig);
    return sig ? 5'h0F : 5'h1F;
  endfunction
endpackage

// File: rtl/hfrf_ptr_pair.sv
module hfrf_ptr_pair #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc_wr,
  input  logic         inc_rd,
  output logic [W-1:0] wr_ptr,
  output logic [W-1:0] rd_ptr
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= ONES;
      rd_ptr <= ONES;
    end else begin
      if (inc_wr) wr_ptr <= wr_ptr + ONE;
      if (inc_rd) rd_ptr <= rd_ptr + ONE;
    end
  end

  // R1 / R2: a reset cycle leaves both pointers at all ones
  a_r1_reset_ones: assert property (@(posedge clk)
    clr |=> (wr_ptr == ONES && rd_ptr == ONES));
endmodule

// File: rtl/hfrf_byte_ram.sv
module hfrf_byte_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hfrf_ovf_monitor.sv
module hfrf_ovf_monitor #(
  parameter int              ZW    = 13,
  parameter int              DAW   = 8,
  parameter logic [4:0]      FMASK = 5'h1F
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          byte_wr,
  input  logic          byte_rd,
  input  logic [ZW-1:0] fill,
  input  logic          eof,
  input  logic          rel_ok,
  input  logic [4:0]    fcount,
  output logic          overflow
);
  localparam logic [ZW-1:0] CAP = ZW'(1) << DAW;

  logic byte_ovf, frame_ovf;

  always_comb begin
    byte_ovf  = byte_wr && !byte_rd && (fill == CAP);
    frame_ovf = eof && !rel_ok && (fcount == FMASK);
  end

  always_ff @(posedge clk) begin
    if (clr)                       overflow <= 1'b0;
    else if (byte_ovf || frame_ovf) overflow <= 1'b1;
  end

  // R11: the flag holds until a reset
  a_r11_sticky: assert property (@(posedge clk) disable iff (clr)
    overflow |=> overflow);
endmodule

// File: rtl/hdlc_rx_frame_fifo.sv
module hdlc_rx_frame_fifo
  import hfrf_pkg::*;
#(
  parameter bit SIG_CHAN   = 1'b0,
  parameter int DEPTH_LOG2 = 8,
  localparam int ZW        = byte_ptr_width(SIG_CHAN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic              rd_en,
  input  logic              rd_frame_done,
  output logic [BYTE_W-1:0] rd_data,
  output logic [ZW-1:0]     wr_byte_ptr,
  output logic [ZW-1:0]     rd_byte_ptr,
  output logic [FRAME_W-1:0] wr_frame_ptr,
  output logic [FRAME_W-1:0] rd_frame_ptr,
  output logic [FRAME_W-1:0] frame_count,
  output logic [ZW-1:0]     byte_fill,
  output logic              overflow
);
  localparam logic [FRAME_W-1:0] FMASK = frame_mask(SIG_CHAN);

  logic                clr;
  logic [ZW-1:0]       z_wr, z_rd;
  logic [FRAME_W-1:0]  f_wr, f_rd;
  logic [FRAME_W-1:0]  fcnt_now, fcnt_next;
  logic [ZW-1:0]       fill_now, fill_next;
  logic                rel_ok;

  assign clr = rst | soft_rst;

  always_comb begin
    fcnt_now  = (f_wr - f_rd) & FMASK;
    rel_ok    = rd_frame_done && (fcnt_now != '0);
    fcnt_next = (f_wr + FRAME_W'(wr_eof) - f_rd - FRAME_W'(rel_ok)) & FMASK;
    fill_now  = z_wr - z_rd;
    fill_next = z_wr + ZW'(wr_en) - z_rd - ZW'(rd_en);
  end

  hfrf_ptr_pair #(.W(ZW)) u_byte_ptrs (
    .clk(clk), .clr(clr), .inc_wr(wr_en), .inc_rd(rd_en),
    .wr_ptr(z_wr), .rd_ptr(z_rd)
  );

  hfrf_ptr_pair #(.W(FRAME_W)) u_frame_ptrs (
    .clk(clk), .clr(clr), .inc_wr(wr_eof), .inc_rd(rel_ok),
    .wr_ptr(f_wr), .rd_ptr(f_rd)
  );

  hfrf_byte_ram #(.AW(DEPTH_LOG2), .DW(BYTE_W)) u_store (
    .clk(clk),
    .we(wr_en), .waddr(z_wr[DEPTH_LOG2-1:0]), .wdata(wr_data),
    .re(rd_en), .raddr(z_rd[DEPTH_LOG2-1:0]), .rdata(rd_data)
  );

  hfrf_ovf_monitor #(.ZW(ZW), .DAW(DEPTH_LOG2), .FMASK(FMASK)) u_ovf (
    .clk(clk), .clr(clr),
    .byte_wr(wr_en), .byte_rd(rd_en), .fill(fill_now),
    .eof(wr_eof), .rel_ok(rel_ok), .fcount(fcnt_now),
    .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      frame_count <= '0;
      byte_fill   <= '0;
    end else begin
      frame_count <= fcnt_next;
      byte_fill   <= fill_next;
    end
  end

  assign wr_byte_ptr  = z_wr;
  assign rd_byte_ptr  = z_rd;
  assign wr_frame_ptr = f_wr & FMASK;
  assign rd_frame_ptr = f_rd & FMASK;

  // R4: a write is never refused
  a_r4_write_advances: assert property (@(posedge clk) disable iff (clr)
    wr_en |=> wr_byte_ptr == ZW'($past(wr_byte_ptr) + ZW'(1)));

  // R7: release on an empty buffer leaves the read frame pointer alone
  a_r7_empty_release: assert property (@(posedge clk) disable iff (clr)
    (frame_count == '0) |=> rd_frame_ptr == $past(rd_frame_ptr));

  // R8: count stays inside the configured range
  a_r8_count_range: assert property (@(posedge clk) disable iff (clr)
    frame_count <= FMASK);

  // R9: a frame beyond the limit raises the flag
  a_r9_frame_ovf: assert property (@(posedge clk) disable iff (clr)
    (wr_eof && !rd_frame_done && frame_count == FMASK) |=> overflow);

  // R10: a byte beyond capacity raises the flag
  a_r10_byte_ovf: assert property (@(posedge clk) disable iff (clr)
    (wr_en && !rd_en && byte_fill == (ZW'(1) << DEPTH_LOG2)) |=> overflow);
endmodule

// File: tb/hdlc_rx_frame_fifo_bench.sv
module hdlc_rx_frame_fifo_bench;
  localparam int DAW = 4;
  localparam int CAP = 1 << DAW;

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0;
  logic wr_en = 1'b0, wr_eof = 1'b0, rd_en = 1'b0, rd_frame_done = 1'b0;
  logic [7:0] wr_data = 8'h00;

  logic [7:0]  rd_b, rd_s;
  logic [12:0] wbp_b, rbp_b, fill_b;
  logic [8:0]  wbp_s, rbp_s, fill_s;
  logic [4:0]  wfp_b, rfp_b, cnt_b, wfp_s, rfp_s, cnt_s;
  logic        ovf_b, ovf_s;

  always #10 clk = ~clk;

  hdlc_rx_frame_fifo #(.SIG_CHAN(1'b0), .DEPTH_LOG2(DAW)) u_hdlc_rx_frame_fifo (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eof(wr_eof), .rd_en(rd_en), .rd_frame_done(rd_frame_done), .rd_data(rd_b),
    .wr_byte_ptr(wbp_b), .rd_byte_ptr(rbp_b), .wr_frame_ptr(wfp_b),
    .rd_frame_ptr(rfp_b), .frame_count(cnt_b), .byte_fill(fill_b), .overflow(ovf_b)
  );

  hdlc_rx_frame_fifo #(.SIG_CHAN(1'b1), .DEPTH_LOG2(DAW)) u_sig (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eof(wr_eof), .rd_en(rd_en), .rd_frame_done(rd_frame_done), .rd_data(rd_s),
    .wr_byte_ptr(wbp_s), .rd_byte_ptr(rbp_s), .wr_frame_ptr(wfp_s),
    .rd_frame_ptr(rfp_s), .frame_count(cnt_s), .byte_fill(fill_s), .overflow(ovf_s)
  );

  int n_chk = 0, n_bad = 0;

  // arithmetic model
  logic [12:0] mz1_b, mz2_b;
  logic [8:0]  mz1_s, mz2_s;
  logic [4:0]  mf1, mf2_b, mf2_s;
  logic        mov_b, mov_s;
  logic [7:0]  mmem [CAP];
  logic [7:0]  exp_rd;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    mz1_b = '1; mz2_b = '1; mz1_s = '1; mz2_s = '1;
    mf1 = '1; mf2_b = '1; mf2_s = '1;
    mov_b = 1'b0; mov_s = 1'b0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " wbp_b"}, 32'(wbp_b), 32'(mz1_b));
    chk({tag, " rbp_b"}, 32'(rbp_b), 32'(mz2_b));
    chk({tag, " fill_b R8"}, 32'(fill_b), 32'(13'(mz1_b - mz2_b)));
    chk({tag, " wfp_b"}, 32'(wfp_b), 32'(mf1));
    chk({tag, " rfp_b"}, 32'(rfp_b), 32'(mf2_b));
    chk({tag, " cnt_b R8"}, 32'(cnt_b), 32'(5'(mf1 - mf2_b)));
    chk({tag, " ovf_b"}, 32'(ovf_b), 32'(mov_b));
    chk({tag, " wbp_s R3"}, 32'(wbp_s), 32'(mz1_s));
    chk({tag, " rbp_s R3"}, 32'(rbp_s), 32'(mz2_s));
    chk({tag, " fill_s R8"}, 32'(fill_s), 32'(9'(mz1_s - mz2_s)));
    chk({tag, " wfp_s R3"}, 32'(wfp_s), 32'(mf1 & 5'h0F));
    chk({tag, " rfp_s R3"}, 32'(rfp_s), 32'(mf2_s & 5'h0F));
    chk({tag, " cnt_s R8"}, 32'(cnt_s), 32'((mf1 - mf2_s) & 5'h0F));
    chk({tag, " ovf_s"}, 32'(ovf_s), 32'(mov_s));
  endtask

  // one clock cycle; called at a falling edge
  task automatic cyc(input logic we, input logic [7:0] d, input logic eof,
                     input logic re, input logic rel);
    logic [4:0] cb, cs;
    logic       rb, rs;
    wr_en = we; wr_data = d; wr_eof = eof; rd_en = re; rd_frame_done = rel;
    cb = 5'(mf1 - mf2_b);
    cs = (mf1 - mf2_s) & 5'h0F;
    rb = rel && (cb != 0);
    rs = rel && (cs != 0);
    if (eof && !rb && cb == 5'h1F) mov_b = 1'b1;
    if (eof && !rs && cs == 5'h0F) mov_s = 1'b1;
    if (we && !re && 13'(mz1_b - mz2_b) == 13'(CAP)) mov_b = 1'b1;
    if (we && !re && 9'(mz1_s - mz2_s) == 9'(CAP)) mov_s = 1'b1;
    if (re) exp_rd = mmem[mz2_b[DAW-1:0]];
    if (we) mmem[mz1_b[DAW-1:0]] = d;
    mz1_b += 13'(we); mz1_s += 9'(we);
    mz2_b += 13'(re); mz2_s += 9'(re);
    mf1 += 5'(eof);
    mf2_b += 5'(rb); mf2_s += 5'(rs);
    @(negedge clk);
    wr_en = 1'b0; wr_eof = 1'b0; rd_en = 1'b0; rd_frame_done = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 after reset");
    chk("R1 reset wbp_b", 32'(wbp_b), 32'h1FFF);
    chk("R1 reset wbp_s", 32'(wbp_s), 32'h1FF);
    chk("R1 reset wfp_s masked", 32'(wfp_s), 32'h0F);

    // R4 wrap from all ones, R5 frames: 3 bytes with eof on last, 5 bytes + bare marker
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'hA0 + 8'(i), i == 2, 1'b0, 1'b0);
    check_all("R4 R5 first frame");
    chk("R4 wrap to 2", 32'(wbp_b), 32'h2);
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'h50 + 8'(i), 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check_all("R5 second frame");
    chk("R8 count 2", 32'(cnt_b), 32'd2);

    // R6 read back all bytes
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      chk("R6 rd_data bearer", 32'(rd_b), 32'(exp_rd));
      chk("R6 rd_data signalling", 32'(rd_s), 32'(exp_rd));
    end
    // R7 release two, then one extra ignored
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check_all("R7 released");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check_all("R7 empty release ignored");
    chk("R7 count zero", 32'(cnt_b), 32'd0);

    // R9 frame overflow: signalling at 16th, bearer at 32nd
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0; model_reset();
    check_all("R2 soft reset");
    for (int i = 1; i <= 32; i++) begin
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      if (i == 15 || i == 16 || i == 31 || i == 32) check_all("R9 frame run");
    end
    chk("R9 bearer ovf", 32'(ovf_b), 32'd1);
    chk("R9 signalling ovf", 32'(ovf_s), 32'd1);
    repeat (3) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check_all("R11 held");
    chk("R11 sticky", 32'(ovf_b), 32'd1);

    // R2 soft reset clears flag
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0; model_reset();
    check_all("R2 clears overflow");
    chk("R2 ovf cleared", 32'(ovf_s), 32'd0);

    // R10 byte overflow: 16 fit, 17th overflows yet is written
    for (int i = 0; i < CAP; i++) cyc(1'b1, 8'(i * 7), 1'b0, 1'b0, 1'b0);
    check_all("R10 full store");
    chk("R10 no ovf at cap", 32'(ovf_b), 32'd0);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0);
    check_all("R10 beyond cap");
    chk("R10 ovf", 32'(ovf_b), 32'd1);
    chk("R10 write taken", 32'(fill_b), 32'(CAP + 1));

    // R1 hard reset again
    rst = 1'b1; @(negedge clk); model_reset();
    check_all("R1 hard reset");
    rst = 1'b0; @(negedge clk);
    check_all("R1 idle");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule